// File: doc/BRIEF.md
# Nested Interrupt Controller with Hardware Return Stack

This block gathers sixteen interrupt sources and serves them to a processor core. Sources 0 to 3 are internal: 0 is a UART byte received, 1 is a UART byte transmitted, 2 is a timer overflow and 3 is an ALU overflow. Sources 4 to 15 are the twelve external lines, so external line j is source 4+j. A request latches into a pending flag. A software-written enable mask selects which pending flags may interrupt the core. When more than one enabled request is pending, the block picks one by a fixed priority and forms a vector address from a programmable page base.

When the core accepts an interrupt, the block saves the core's return address and status word in an on-chip LIFO of sixteen entries. This allows interrupts to nest sixteen deep without any stores to memory. A return-from-interrupt strobe pops the newest entry, and the restored values appear on the top-of-stack outputs. Software reaches the control and status registers through a small select/read/write port, which the core drives from its move-processor-status instruction.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, intr_req is 0, every pending flag and every mask bit is 0, the page base is 0 and the stack is empty, so top_pc and top_status read 0.
- R2: A 1 on source input i in a cycle sets pending flag i at the next clock edge. The flag then stays set until that source is acknowledged. Register select 1 reads all sixteen pending flags, with bit i for source i, whatever the mask holds.
- R3: Register select 2 is the read/write enable mask, where bit i = 1 enables source i. Register select 0 reads the pending flags ANDed with the mask. A pending source whose mask bit is 0 neither raises intr_req nor takes part in selection.
- R4: Among the pending, enabled sources, the lowest-numbered one wins. Its number appears on intr_id.
- R5: vec_addr equals the page base plus four times intr_id. Register select 4 writes the page base and always reads 0. Register select 3 reads vec_addr.
- R6: A cpu_take pulse while intr_req is 1 pushes {cpu_ret_pc, cpu_status} onto the stack and clears the pending flag of the selected source. From the next cycle, top_pc and top_status show the pushed pair.
- R7: A cpu_reti pulse removes the newest entry, and top_pc and top_status then show the entry beneath it, or 0 when the stack is empty. Register select 5 reads top_pc. A cpu_reti pulse on an empty stack changes nothing.
- R8: While sixteen entries are stored, intr_req is 0 and a cpu_take pulse is ignored. Requests stay pending and are served once a return frees an entry.
- R9: If cpu_take and cpu_reti are both 1 in a cycle in which intr_req is 1, the take is carried out and the return is ignored.
- R10: If a source's input is 1 in the same cycle in which that source is acknowledged, its pending flag stays set.
- R11: Register selects 6 and 7 read 0, and writes to them, or to the read-only selects, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_int | input | 4 | Internal requests, sources 0..3 |
| irq_ext | input | 12 | External requests, sources 4..15 |
| intr_req | output | 1 | An enabled interrupt is pending and the stack has room |
| intr_id | output | 4 | Number of the selected source |
| vec_addr | output | 32 | Service routine address for intr_id |
| cpu_take | input | 1 | Core accepts the offered interrupt |
| cpu_ret_pc | input | 32 | Return address to save on take |
| cpu_status | input | 8 | Status word to save on take |
| cpu_reti | input | 1 | Core returns from an interrupt |
| top_pc | output | 32 | Newest saved return address (0 if empty) |
| top_status | output | 8 | Newest saved status word (0 if empty) |
| reg_sel | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |

## Verification
The bench fills the stack to exactly sixteen entries and then requests again. A design with an off-by-one in the full test would offer or accept a seventeenth interrupt and overwrite the oldest frame. It sends a take and a return in the same cycle, which a naive LIFO would turn into a net pop or a corrupted top entry. It re-raises a source in the very cycle that source is acknowledged, and a design that lets the clear win would lose that request. It also checks the priority with the lowest source masked, returns on an empty stack, and checks that the write-only page register reads as zero, where a wrong read mux would leak its value.

// File: rtl/nic_pkg.sv
package nic_pkg;

   typedef enum logic [2:0] {
      SEL_ENABLED = 3'd0,
      SEL_RAW     = 3'd1,
      SEL_MASK    = 3'd2,
      SEL_VADDR   = 3'd3,
      SEL_VPAGE   = 3'd4,
      SEL_RETPC   = 3'd5,
      SEL_RSV6    = 3'd6,
      SEL_RSV7    = 3'd7
   } nic_reg_e;

   localparam int unsigned VEC_SHIFT = 2;

endpackage

// File: rtl/nic_flags.sv
module nic_flags #(
   parameter int unsigned N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);

   generate
      for (genvar g = 0; g < N; g++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)
               pend_o[g] <= 1'b0;
            else if (set_i[g])
               pend_o[g] <= 1'b1;
            else if (clr_i[g])
               pend_o[g] <= 1'b0;
         end
      end
   endgenerate

   // R2: a request always leaves its flag set on the next cycle
   a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
   parameter int unsigned N         = 16,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned IDW      = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   act_i,
   output logic           any_o,
   output logic [IDW-1:0] id_o
);

   assign any_o = |act_i;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            id_o = '0;
            for (int i = N - 1; i >= 0; i--)
               if (act_i[i]) id_o = IDW'(i);
         end
         // R4: nothing below the winner is active
         a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
            any_o |-> ((act_i & ~({N{1'b1}} << id_o)) == '0));
      end else begin : g_high
         always_comb begin
            id_o = '0;
            for (int i = 0; i < N; i++)
               if (act_i[i]) id_o = IDW'(i);
         end
      end
   endgenerate

   // R4: the selected source is one that is actually requesting
   a_r4_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> act_i[id_o]);

endmodule

// File: rtl/nic_stack.sv
module nic_stack #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 32,
   parameter int unsigned SW    = 8,
   localparam int unsigned CW   = $clog2(DEPTH + 1),
   localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [AW-1:0] pc_i,
   input  logic [SW-1:0] st_i,
   output logic [AW-1:0] top_pc_o,
   output logic [SW-1:0] top_st_o,
   output logic          full_o,
   output logic          empty_o
);

   logic [AW-1:0] pc_mem [DEPTH];
   logic [SW-1:0] st_mem [DEPTH];
   logic [CW-1:0] cnt;
   logic [CW-1:0] top_ix;

   assign full_o  = (cnt == CW'(DEPTH));
   assign empty_o = (cnt == '0);
   assign top_ix  = cnt - CW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (push_i)
         cnt <= cnt + CW'(1);
      else if (pop_i)
         cnt <= cnt - CW'(1);
   end

   always_ff @(posedge clk) begin
      if (push_i) begin
         pc_mem[cnt[IW-1:0]] <= pc_i;
         st_mem[cnt[IW-1:0]] <= st_i;
      end
   end

   assign top_pc_o = empty_o ? '0 : pc_mem[top_ix[IW-1:0]];
   assign top_st_o = empty_o ? '0 : st_mem[top_ix[IW-1:0]];

   // R6: a push grows the stack by one and shows the pushed frame
   a_r6_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> (cnt == $past(cnt) + CW'(1)) && (top_pc_o == $past(pc_i)));
   // R7: a pop shrinks the stack by one
   a_r7_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i) |=> (cnt == $past(cnt) - CW'(1)));
   // R8: the controller never pushes into a full stack
   a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   // R9: push and pop are never issued together
   a_r9_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
   parameter int unsigned N_INT     = 4,
   parameter int unsigned N_EXT     = 12,
   parameter int unsigned AW        = 32,
   parameter int unsigned SW        = 8,
   parameter int unsigned DEPTH     = 16,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned N_SRC    = N_INT + N_EXT,
   localparam int unsigned IDW      = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_INT-1:0] irq_int,
   input  logic [N_EXT-1:0] irq_ext,
   output logic             intr_req,
   output logic [IDW-1:0]   intr_id,
   output logic [AW-1:0]    vec_addr,
   input  logic             cpu_take,
   input  logic [AW-1:0]    cpu_ret_pc,
   input  logic [SW-1:0]    cpu_status,
   input  logic             cpu_reti,
   output logic [AW-1:0]    top_pc,
   output logic [SW-1:0]    top_status,
   input  logic [2:0]       reg_sel,
   input  logic             reg_we,
   input  logic [AW-1:0]    reg_wdata,
   output logic [AW-1:0]    reg_rdata
);

   import nic_pkg::*;

   generate
      if (N_SRC > AW) begin : g_chk_width
         $error("source count exceeds register width");
      end
      if (DEPTH < 2) begin : g_chk_depth
         $error("stack depth must be at least 2");
      end
      if (N_INT == 0) begin : g_chk_int
         $error("at least one internal source is required");
      end
   endgenerate

   logic [N_SRC-1:0] req_in;
   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] mask_q;
   logic [N_SRC-1:0] enabled;
   logic [N_SRC-1:0] clr_oh;
   logic [AW-1:0]    vpage_q;
   logic             any_en;
   logic             stk_full;
   logic             stk_empty;
   logic             take_ok;
   logic             reti_ok;
   nic_reg_e         sel_e;

   assign req_in  = {irq_ext, irq_int};
   assign enabled = pend & mask_q;
   assign sel_e   = nic_reg_e'(reg_sel);

   nic_flags #(.N(N_SRC)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (req_in),
      .clr_i  (clr_oh),
      .pend_o (pend)
   );

   nic_arbiter #(.N(N_SRC), .LOW_FIRST(LOW_FIRST)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .act_i (enabled),
      .any_o (any_en),
      .id_o  (intr_id)
   );

   assign intr_req = any_en && !stk_full;
   assign take_ok  = cpu_take && intr_req;
   assign reti_ok  = cpu_reti && !stk_empty && !take_ok;
   assign clr_oh   = take_ok ? (N_SRC'(1) << intr_id) : '0;
   assign vec_addr = vpage_q + (AW'(intr_id) << VEC_SHIFT);

   nic_stack #(.DEPTH(DEPTH), .AW(AW), .SW(SW)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_i   (take_ok),
      .pop_i    (reti_ok),
      .pc_i     (cpu_ret_pc),
      .st_i     (cpu_status),
      .top_pc_o (top_pc),
      .top_st_o (top_status),
      .full_o   (stk_full),
      .empty_o  (stk_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         vpage_q <= '0;
      end else if (reg_we) begin
         if (sel_e == SEL_MASK)  mask_q  <= reg_wdata[N_SRC-1:0];
         if (sel_e == SEL_VPAGE) vpage_q <= reg_wdata;
      end
   end

   always_comb begin
      case (sel_e)
         SEL_ENABLED: reg_rdata = AW'(enabled);
         SEL_RAW:     reg_rdata = AW'(pend);
         SEL_MASK:    reg_rdata = AW'(mask_q);
         SEL_VADDR:   reg_rdata = vec_addr;
         SEL_RETPC:   reg_rdata = top_pc;
         default:     reg_rdata = '0;
      endcase
   end

   // R3: an interrupt is offered only for an enabled pending source
   a_r3_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      intr_req |-> (enabled != '0));
   // R8: nothing is offered while the stack is full
   a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      stk_full |-> !intr_req);
   // R6: acknowledged source is cleared when not re-requested
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (take_ok && !req_in[intr_id]) |=> !pend[$past(intr_id)]);
   // R10: a request in the acknowledge cycle survives
   a_r10_rerequest_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (take_ok && req_in[intr_id]) |=> pend[$past(intr_id)]);
   // R5: the vector is always word aligned relative to the page base
   a_r5_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      ((vec_addr - vpage_q) & AW'(3)) == '0);

endmodule

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  irq_int = '0;
   logic [11:0] irq_ext = '0;
   logic        intr_req;
   logic [3:0]  intr_id;
   logic [31:0] vec_addr;
   logic        cpu_take = 1'b0;
   logic [31:0] cpu_ret_pc = '0;
   logic [7:0]  cpu_status = '0;
   logic        cpu_reti = 1'b0;
   logic [31:0] top_pc;
   logic [7:0]  top_status;
   logic [2:0]  reg_sel = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   always #2.5 clk = ~clk;

   nest_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .irq_int(irq_int), .irq_ext(irq_ext),
      .intr_req(intr_req), .intr_id(intr_id), .vec_addr(vec_addr),
      .cpu_take(cpu_take), .cpu_ret_pc(cpu_ret_pc), .cpu_status(cpu_status),
      .cpu_reti(cpu_reti), .top_pc(top_pc), .top_status(top_status),
      .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   localparam int K_REQ = 0, K_ID = 1, K_VEC = 2, K_PC = 3, K_ST = 4, K_REG = 5;

   typedef struct {
      string       tag;
      int          kind;
      logic [31:0] exp;
   } item_t;

   item_t q[$];
   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   // monitor: pops expected items and compares against the ports
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = q.pop_front();
         case (it.kind)
            K_REQ:   act = {31'd0, intr_req};
            K_ID:    act = {28'd0, intr_id};
            K_VEC:   act = vec_addr;
            K_PC:    act = top_pc;
            K_ST:    act = {24'd0, top_status};
            default: act = reg_rdata;
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s (kind %0d): actual %h expected %h", it.tag, it.kind, act, it.exp);
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic expect_v(string tag, int kind, logic [31:0] exp);
      item_t it;
      it.tag = tag; it.kind = kind; it.exp = exp;
      q.push_back(it);
   endtask

   task automatic drain();
      @(negedge clk); #1;
      @(posedge clk); #1;
   endtask

   task automatic chk_reg(string tag, logic [2:0] sel, logic [31:0] exp);
      reg_sel = sel;
      expect_v(tag, K_REG, exp);
      drain();
   endtask

   task automatic pulse(logic [15:0] srcs);
      irq_int = srcs[3:0];
      irq_ext = srcs[15:4];
      tick();
      irq_int = '0;
      irq_ext = '0;
   endtask

   task automatic wr(logic [2:0] sel, logic [31:0] d);
      reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic take(logic [31:0] pc, logic [7:0] st);
      cpu_take = 1'b1; cpu_ret_pc = pc; cpu_status = st;
      tick();
      cpu_take = 1'b0;
   endtask

   task automatic reti();
      cpu_reti = 1'b1;
      tick();
      cpu_reti = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();

      // R1 reset state
      expect_v("R1 intr_req", K_REQ, 0);
      expect_v("R1 top_pc", K_PC, 0);
      expect_v("R1 top_status", K_ST, 0);
      drain();
      chk_reg("R1 pending", 3'd1, 0);
      chk_reg("R1 mask", 3'd2, 0);

      // R2 latching, R3 masked sources do not interrupt
      pulse(16'h0042);
      chk_reg("R2 raw pending", 3'd1, 32'h0042);
      chk_reg("R3 enabled view masked", 3'd0, 0);
      expect_v("R3 masked no req", K_REQ, 0);
      drain();

      wr(3'd2, 32'h0000_FFFF);
      chk_reg("R3 mask readback", 3'd2, 32'h0000_FFFF);
      chk_reg("R3 enabled view", 3'd0, 32'h0042);
      expect_v("R3 req", K_REQ, 1);
      expect_v("R4 lowest id", K_ID, 1);
      drain();

      // R5 vector generation, write-only page
      wr(3'd4, 32'h0000_1000);
      chk_reg("R5 page write-only", 3'd4, 0);
      chk_reg("R5 vaddr reg", 3'd3, 32'h0000_1004);
      expect_v("R5 vec", K_VEC, 32'h0000_1004);
      drain();

      // R11 reserved selects and read-only writes
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd1, 32'hFFFF_FFFF);
      chk_reg("R11 reserved reads 0", 3'd6, 0);
      chk_reg("R11 raw unaffected", 3'd1, 32'h0042);

      // R6 take pushes and clears
      take(32'h0000_00A0, 8'h11);
      expect_v("R6 top pc", K_PC, 32'h0000_00A0);
      expect_v("R6 top st", K_ST, 32'h11);
      expect_v("R4 next id", K_ID, 6);
      expect_v("R5 vec id6", K_VEC, 32'h0000_1018);
      drain();
      chk_reg("R6 pending cleared", 3'd1, 32'h0040);
      take(32'h0000_00B0, 8'h22);
      expect_v("R6 nested top", K_PC, 32'h0000_00B0);
      expect_v("R6 no req left", K_REQ, 0);
      drain();

      // R7 returns
      reti();
      expect_v("R7 pop pc", K_PC, 32'h0000_00A0);
      expect_v("R7 pop st", K_ST, 32'h11);
      drain();
      chk_reg("R7 retpc reg", 3'd5, 32'h0000_00A0);
      reti();
      expect_v("R7 empty pc", K_PC, 0);
      drain();
      reti();
      expect_v("R7 empty reti ignored", K_PC, 0);
      expect_v("R7 empty st", K_ST, 0);
      drain();

      // R3/R4 priority with lowest source masked
      wr(3'd2, 32'h0000_FFFE);
      pulse(16'h0021);
      expect_v("R3 masked src0 skipped", K_ID, 5);
      expect_v("R5 vec id5", K_VEC, 32'h0000_1014);
      drain();
      wr(3'd2, 32'h0000_FFFF);
      expect_v("R4 src0 wins", K_ID, 0);
      drain();
      take(32'h0000_00C0, 8'h01);
      take(32'h0000_00D0, 8'h02);

      // R8 fill to sixteen
      for (int i = 0; i < 14; i++) begin
         pulse(16'h8000);
         take(32'h0000_2000 + i, 8'(i));
      end
      expect_v("R8 full top", K_PC, 32'h0000_200D);
      drain();
      pulse(16'h0200);
      expect_v("R8 full no req", K_REQ, 0);
      drain();
      chk_reg("R8 still pending", 3'd1, 32'h0200);
      take(32'h0000_DEAD, 8'hEE);
      expect_v("R8 take ignored", K_PC, 32'h0000_200D);
      drain();
      reti();
      expect_v("R8 served after pop", K_REQ, 1);
      expect_v("R8 id9", K_ID, 9);
      expect_v("R7 top after pop", K_PC, 32'h0000_200C);
      drain();

      // R9 simultaneous take and return
      cpu_reti = 1'b1;
      take(32'h0000_0777, 8'h77);
      cpu_reti = 1'b0;
      expect_v("R9 take wins pc", K_PC, 32'h0000_0777);
      expect_v("R9 take wins st", K_ST, 32'h77);
      expect_v("R9 stack full again", K_REQ, 0);
      drain();
      chk_reg("R9 pending cleared", 3'd1, 0);

      // R10 re-request in acknowledge cycle
      pulse(16'h0008);
      reti();
      expect_v("R10 setup id", K_ID, 3);
      drain();
      irq_int = 4'b1000;
      take(32'h0000_0888, 8'h08);
      irq_int = '0;
      chk_reg("R10 flag kept", 3'd1, 32'h0008);
      expect_v("R10 pushed", K_PC, 32'h0000_0888);
      drain();

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule